// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Unit

This block carries out the atomic read-modify-write primitive of one processor core. It takes the two load-locked and two store-conditional operations and runs them against a small local memory of 64-bit words. A load-locked reads a word or a half-word and arms a single reservation on its effective address. A later store-conditional to that same address commits only while the reservation is still armed. The store-conditional's data register then receives a status value instead of staying unchanged: 1 on commit, 0 on refusal.

Each request carries an opcode, a 64-bit base register value, a 16-bit signed displacement and 64 bits of store data. It is accepted with a valid/ready handshake. Exactly one response pulse follows one cycle later, carrying the value to write back: load data for a load-locked, status for a store-conditional. Only one reservation exists. Every store-conditional consumes it, whether the store commits or not.

Top module: `llsc_unit`

## Requirements
- R1: The effective address is the base value plus the displacement sign-extended from 16 to 64 bits, modulo 2^64.
- R2: Opcode 0x2A (32-bit load-locked) returns the 32-bit half selected by address bit 2 (0 = bits 31:0 of the word, 1 = bits 63:32), sign-extended to 64 bits.
- R3: Opcode 0x2B (64-bit load-locked) returns the full word at word index address bits [3+:IDX_W]; bits 2:0 do not select within the word.
- R4: A load-locked arms the reservation and records its full effective address. A newer load-locked replaces any older reservation.
- R5: A store-conditional commits only when the reservation is armed and its effective address equals the recorded address in all 64 bits; a committed store returns 1.
- R6: A refused store-conditional returns 0 and leaves memory unchanged.
- R7: Every accepted store-conditional disarms the reservation, whether it commits or not, so a second one with no load-locked in between is refused.
- R8: Opcode 0x2E (32-bit store-conditional) writes only the low 32 bits of its data into the half selected by address bit 2; the other half of the word keeps its value. Opcode 0x2F writes the whole word.
- R9: Ready is high whenever reset is not asserted. Each accepted request gives exactly one rsp_valid pulse, in the cycle after acceptance, and rsp_valid is never high otherwise.
- R10: Reset disarms the reservation, clears the recorded address and all memory words to zero, and drops rsp_valid.
- R11: Any other opcode is answered with result 0. It does not touch memory or the reservation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 6 | Operation code |
| req_base | input | 64 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_data | input | 64 | Data register value for stores |
| rsp_valid | output | 1 | Result pulse |
| rsp_data | output | 64 | Load data or store status for writeback |

## Verification
On every cycle, the assertions check the handshake timing: one pulse per acceptance, none otherwise. They also check the reservation state after each operation: armed with the address just computed after a load-locked, disarmed after any store-conditional, untouched by unknown opcodes. Finally, they check that a store status is 1 exactly when the reservation matched. Memory contents can be seen only through later loads, so only the bench's scenarios show the following:
- a refused store leaves its word intact;
- a 32-bit store leaves the other half alone;
- sign extension and half selection are correct;
- reset wipes both memory and reservation.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    localparam int OP_W = 6;

    typedef enum logic [OP_W-1:0] {
        OP_LD32_LOCK = 6'h2A,
        OP_LD64_LOCK = 6'h2B,
        OP_ST32_COND = 6'h2E,
        OP_ST64_COND = 6'h2F
    } llsc_op_e;

    typedef struct packed {
        logic        rdy;
        logic        rsp_vld;
        logic [63:0] rsp_dat;
    } llsc_state_t;
endpackage

// File: rtl/llsc_agen.sv
module llsc_agen #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] ea
);
    localparam int EXT_W = ADDR_W - DISP_W;

    always_comb begin
        ea = base + {{EXT_W{disp[DISP_W-1]}}, disp};
    end
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              disarm,
    input  logic [ADDR_W-1:0] ea,
    output logic              hit,
    output logic              lock,
    output logic [ADDR_W-1:0] lock_addr
);
    typedef struct packed {
        logic              lock;
        logic [ADDR_W-1:0] addr;
    } resv_t;

    resv_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (arm) begin
            r_d.lock = 1'b1;
            r_d.addr = ea;
        end else if (disarm) begin
            r_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hit       = r_q.lock && (r_q.addr == ea);
    assign lock      = r_q.lock;
    assign lock_addr = r_q.addr;
endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
    parameter int WORDS  = 16,
    parameter int DATA_W = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(WORDS)-1:0] idx,
    input  logic                     we,
    input  logic [1:0]               half_en,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] mem_q [WORDS];

    for (genvar h = 0; h < 2; h++) begin : g_half
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int w = 0; w < WORDS; w++) begin
                    mem_q[w][h*HALF_W +: HALF_W] <= '0;
                end
            end else if (we && half_en[h]) begin
                mem_q[idx][h*HALF_W +: HALF_W] <= wdata[h*HALF_W +: HALF_W];
            end
        end
    end

    assign rdata = mem_q[idx];
endmodule

// File: rtl/llsc_unit.sv
module llsc_unit
    import llsc_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int DATA_W    = 64,
    parameter int DISP_W    = 16,
    parameter int MEM_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OP_W-1:0]   req_op,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [DISP_W-1:0] req_disp,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int IDX_W  = $clog2(MEM_WORDS);
    localparam int HALF_W = DATA_W / 2;

    llsc_state_t st_d, st_q;

    logic [ADDR_W-1:0] ea;
    logic              acc, is_ll, is_sc;
    logic              sc_hit, resv_lock;
    logic [ADDR_W-1:0] resv_addr;
    logic              mem_we;
    logic [1:0]        mem_half;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic [HALF_W-1:0] ld_half;
    logic [IDX_W-1:0]  widx;

    llsc_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
        .base (req_base),
        .disp (req_disp),
        .ea   (ea)
    );

    assign acc   = req_valid && st_q.rdy;
    assign is_ll = (req_op == OP_LD32_LOCK) || (req_op == OP_LD64_LOCK);
    assign is_sc = (req_op == OP_ST32_COND) || (req_op == OP_ST64_COND);
    assign widx  = ea[3 +: IDX_W];

    llsc_resv #(.ADDR_W(ADDR_W)) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (acc && is_ll),
        .disarm    (acc && is_sc),
        .ea        (ea),
        .hit       (sc_hit),
        .lock      (resv_lock),
        .lock_addr (resv_addr)
    );

    always_comb begin
        mem_we    = acc && is_sc && sc_hit;
        mem_half  = 2'b11;
        mem_wdata = req_data;
        if (req_op == OP_ST32_COND) begin
            mem_half  = ea[2] ? 2'b10 : 2'b01;
            mem_wdata = {req_data[HALF_W-1:0], req_data[HALF_W-1:0]};
        end
    end

    llsc_mem #(.WORDS(MEM_WORDS), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (widx),
        .we      (mem_we),
        .half_en (mem_half),
        .wdata   (mem_wdata),
        .rdata   (mem_rdata)
    );

    assign ld_half = ea[2] ? mem_rdata[DATA_W-1:HALF_W] : mem_rdata[HALF_W-1:0];

    always_comb begin
        st_d         = st_q;
        st_d.rdy     = 1'b1;
        st_d.rsp_vld = acc;
        if (acc) begin
            unique case (req_op)
                OP_LD32_LOCK: st_d.rsp_dat = {{HALF_W{ld_half[HALF_W-1]}}, ld_half};
                OP_LD64_LOCK: st_d.rsp_dat = mem_rdata;
                OP_ST32_COND,
                OP_ST64_COND: st_d.rsp_dat = {{(DATA_W-1){1'b0}}, sc_hit};
                default:      st_d.rsp_dat = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = st_q.rdy;
    assign rsp_valid = st_q.rsp_vld;
    assign rsp_data  = st_q.rsp_dat;
endmodule

// File: rtl/llsc_unit_chk.sv
module llsc_unit_chk #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc,
    input logic              is_ll,
    input logic              is_sc,
    input logic              sc_hit,
    input logic [ADDR_W-1:0] ea,
    input logic              lock,
    input logic [ADDR_W-1:0] lock_addr,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data
);
    // R9
    resp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    // R9
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);

    // R4
    ll_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_ll) |=> (lock && lock_addr == $past(ea)));

    // R7
    sc_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_sc) |=> !lock);

    // R5
    sc_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_sc && sc_hit) |=> (rsp_data == 64'd1));

    // R6
    sc_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_sc && !sc_hit) |=> (rsp_data == 64'd0));

    // R11
    other_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !is_ll && !is_sc) |=> (rsp_data == 64'd0 && $stable(lock) && $stable(lock_addr)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!lock && lock_addr == '0 && !rsp_valid));
endmodule

bind llsc_unit llsc_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .is_ll     (is_ll),
    .is_sc     (is_sc),
    .sc_hit    (sc_hit),
    .ea        (ea),
    .lock      (resv_lock),
    .lock_addr (resv_addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
);

// File: tb/llsc_unit_tb.sv
module llsc_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 21;
    localparam int VEC_W = 6 + 64 + 16 + 64 + 64;

    localparam logic [5:0] LDL = 6'h2A, LDQ = 6'h2B, STL = 6'h2E, STQ = 6'h2F;

    // op, base, disp, data, expected result
    localparam logic [VEC_W-1:0] VEC [NVEC] = '{
        {LDQ, 64'h40,   16'hFFF8, 64'h0, 64'h0},                    // R1 R3 EA 0x38
        {STQ, 64'h30,   16'h0008, 64'h1122334455667788, 64'h1},     // R5 EA 0x38 match
        {LDQ, 64'h38,   16'h0000, 64'h0, 64'h1122334455667788},     // R3
        {STQ, 64'h38,   16'h0000, 64'hDEAD, 64'h1},                 // R5
        {STQ, 64'h38,   16'h0000, 64'hBEEF, 64'h0},                 // R7 lock consumed
        {LDQ, 64'h38,   16'h0000, 64'h0, 64'hDEAD},                 // R6
        {LDL, 64'h20,   16'h0004, 64'h0, 64'h0},                    // R2 EA 0x24
        {STL, 64'h24,   16'h0000, 64'hFFFFFFFF80000001, 64'h1},     // R8
        {LDL, 64'h24,   16'h0000, 64'h0, 64'hFFFFFFFF80000001},     // R2 sign ext
        {LDQ, 64'h20,   16'h0000, 64'h0, 64'h8000000100000000},     // R8 low half kept
        {STQ, 64'h21,   16'h0000, 64'h5, 64'h0},                    // R5 exact mismatch
        {LDQ, 64'h20,   16'h0000, 64'h0, 64'h8000000100000000},     // R6
        {LDL, 64'h10,   16'h0000, 64'h0, 64'h0},                    // R4
        {LDL, 64'h18,   16'h0000, 64'h0, 64'h0},                    // R4 replaces
        {STL, 64'h10,   16'h0000, 64'h7, 64'h0},                    // R4 old resv gone
        {LDQ, 64'h08,   16'h0000, 64'h0, 64'h0},                    // R11 setup
        {6'h11, 64'h08, 16'h0000, 64'h55, 64'h0},                   // R11 other op
        {STQ, 64'h08,   16'h0000, 64'h9, 64'h1},                    // R11 lock intact
        {LDQ, 64'h08,   16'h0000, 64'h0, 64'h9},                    // R11 mem intact
        {LDQ, 64'h8028, 16'h8000, 64'h0, 64'h0},                    // R1 negative disp EA 0x28
        {STQ, 64'h28,   16'h0000, 64'h3, 64'h1}                     // R1 R5 same EA
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [5:0]  req_op = '0;
    logic [63:0] req_base = '0;
    logic [15:0] req_disp = '0;
    logic [63:0] req_data = '0;
    logic        rsp_valid;
    logic [63:0] rsp_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    llsc_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_base  (req_base),
        .req_disp  (req_disp),
        .req_data  (req_data),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_req(input logic [5:0] op, input logic [63:0] base, input logic [15:0] disp,
                          input logic [63:0] data, input logic [63:0] exp, input string req);
        @(negedge clk);
        req_valid = 1'b1;
        req_op = op;
        req_base = base;
        req_disp = disp;
        req_data = data;
        @(negedge clk);
        check(rsp_valid === 1'b1, {req, " R9 pulse"}, {63'd0, rsp_valid}, 64'd1);
        check(rsp_data === exp, req, rsp_data, exp);
        req_valid = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!finished && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        repeat (2) @(negedge clk);
        check(rsp_valid === 1'b0, "R10 rsp low in reset", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1, "R9 ready after reset", {63'd0, req_ready}, 64'd1);
        check(rsp_valid === 1'b0, "R9 idle no rsp", {63'd0, rsp_valid}, 64'd0);
        // R10 reset lock clear, address zero: SC at EA 0 refused
        do_req(STQ, 64'h0, 16'h0, 64'h1234, 64'h0, "R10 no lock at addr 0");
        do_req(LDQ, 64'h0, 16'h0, 64'h0, 64'h0, "R10 memory zero");

        // vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic [VEC_W-1:0] v;
            v = VEC[i];
            do_req(v[213:208], v[207:144], v[143:128], v[127:64], v[63:0], $sformatf("vector %0d R1-set", i));
            @(negedge clk);
            check(rsp_valid === 1'b0, "R9 single pulse", {63'd0, rsp_valid}, 64'd0);
        end

        // R9 back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_op = LDQ; req_base = 64'h38; req_disp = '0; req_data = '0;
        @(negedge clk);
        check(rsp_valid === 1'b1 && rsp_data === 64'hDEAD, "R9 b2b first", rsp_data, 64'hDEAD);
        req_op = STQ; req_data = 64'h77;
        @(negedge clk);
        check(rsp_valid === 1'b1 && rsp_data === 64'h1, "R9 b2b second", rsp_data, 64'h1);
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid === 1'b0, "R9 b2b end", {63'd0, rsp_valid}, 64'd0);
        do_req(LDQ, 64'h38, 16'h0, 64'h0, 64'h77, "R5 b2b store landed");

        // R10 reset mid-run drops reservation and memory
        do_req(LDQ, 64'h08, 16'h0, 64'h0, 64'h9, "R3 before reset");
        apply_reset();
        do_req(STQ, 64'h08, 16'h0, 64'h4, 64'h0, "R10 resv dropped");
        do_req(LDQ, 64'h08, 16'h0, 64'h0, 64'h0, "R10 memory wiped");

        // R8 low-half store into upper-filled word
        do_req(LDQ, 64'h48, 16'h0, 64'h0, 64'h0, "R8 setup");
        do_req(STQ, 64'h48, 16'h0, 64'hCAFEF00D00000000, 64'h1, "R8 setup store");
        do_req(LDL, 64'h48, 16'h0, 64'h0, 64'h0, "R2 low half zero");
        do_req(STL, 64'h48, 16'h0, 64'hFFFFFFFF12345678, 64'h1, "R8 low store");
        do_req(LDQ, 64'h48, 16'h0, 64'h0, 64'hCAFEF00D12345678, "R8 high half kept");
        do_req(LDL, 64'h4C, 16'h0, 64'h0, 64'hFFFFFFFFCAFEF00D, "R2 high half sext");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule